// File: doc/BRIEF.md
# March-Test Memory Self-Test Controller

This block drives a single-port synchronous RAM through one of three march-style test algorithms and judges the result on its own. Each algorithm is a fixed list of elements. An element walks every address in ascending or descending order and applies one or two operations to a cell before moving to the next address. The controller produces the address, write data, write enable and read enable. It predicts the word every read should return and compares the returned word one cycle later.

A start pulse, together with a 2-bit algorithm code, launches a run while the controller is idle. The three algorithms are:
- a three-element march with a rising element and a falling element;
- the four-element zero/one scan;
- the same scan on a checkerboard background, where a cell's value depends on the parity of its row and column.

At the end of the run the controller raises `done`. On a failure it also raises `fail` and keeps the address, element number and observed word of the first miscompare. All of these results hold until the next start.

Top module: `mbist_march`

## Requirements
- R1: After reset `busy`, `done` and `fail` are 0 and neither `mem_we` nor `mem_re` is asserted.
- R2: A `start` pulse is taken only while `busy` is 0, and the algorithm code is captured with it. A `start` pulse while `busy` is 1 has no effect on the access sequence.
- R3: At most one access is issued per cycle, so `mem_we` and `mem_re` are never both 1. No access is issued while `busy` is 0.
- R4: Code 0 runs three elements, 5·DEPTH accesses in all. Element 0 writes all-zero words at ascending addresses. Element 1 goes ascending and, at each address, reads expecting all-zero and then writes all-ones. Element 2 goes descending and, at each address, reads expecting all-ones and then writes all-zero.
- R5: Code 1 runs four ascending elements, 4·DEPTH accesses in all: write all-zero, read all-zero, write all-ones, read all-ones.
- R6: Code 2 runs the four-element shape of R5 on a checkerboard background. The row is the upper ROW_W address bits and the column is the lower bits. Let the class bit be row bit 0 XOR column bit 0, which is address bit ROW_W... more precisely address bit (ADDR_W−ROW_W) XOR address bit 0. In elements 0 and 1 each cell holds a word of all copies of its class bit. In elements 2 and 3 each cell holds the inverse.
- R7: A descending element visits DEPTH−1 down to 0, the exact reverse of the ascending order. Each element completes all its operations at one address before it moves on.
- R8: Read data is compared in the cycle after the read is issued. The first mismatching read sets `fail` and latches `fail_addr`, `fail_elem` and `fail_data`. Later mismatches in the same run leave these unchanged.
- R9: `done` rises once, two cycles after the last access, and no access occurs in the cycle it rises. `done`, `fail` and the latched failure fields then hold until the next accepted start.
- R10: Code 3 issues no access and ends with `done` = 1 and `fail` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, taken when idle |
| algo | input | 2 | Algorithm code: 0 three-element march, 1 zero/one scan, 2 checkerboard scan, 3 no operation |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after `mem_re` |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run complete, held until next start |
| fail | output | 1 | A miscompare was seen, held until next start |
| fail_addr | output | ADDR_W | Address of the first miscompare |
| fail_elem | output | 2 | Element number of the first miscompare |
| fail_data | output | DATA_W | Word returned by the first miscompare |

## Verification
The hardest thing to provoke is a failure whose reported position shows the march order. Two faulty cells must both miscompare, and the element direction alone must decide which one is reported first. The bench's RAM model applies stuck bits to chosen cells on every read. Two cells stuck at 1 must be caught at the lower address during the ascending element. Two cells stuck at 0 must be caught at the higher address during the descending element. Random single stuck bits are also placed by a seeded generator in every algorithm, and a start pulse is injected in the middle of a run.

// File: rtl/mbist_march.sv
module mbist_march #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int ROW_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        algo,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [1:0]        fail_elem,
  output logic [DATA_W-1:0] fail_data
);
  localparam int COL_W = ADDR_W - ROW_W;
  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  // descriptor: {last, down, two_ops, first_is_read, val0, val1}
  function automatic logic [5:0] desc(input logic [1:0] a, input logic [1:0] e);
    if (a == 2'd0) begin
      case (e)
        2'd0:    desc = 6'b000000;
        2'd1:    desc = 6'b001101;
        default: desc = 6'b111110;
      endcase
    end else begin
      case (e)
        2'd0:    desc = 6'b000000;
        2'd1:    desc = 6'b000100;
        2'd2:    desc = 6'b000010;
        default: desc = 6'b100110;
      endcase
    end
  endfunction

  logic              run, fin, opi;
  logic [1:0]        algo_q, elem;
  logic [ADDR_W-1:0] addr;
  logic              rd_pend, rd_exp;
  logic [ADDR_W-1:0] rd_addr;
  logic [1:0]        rd_elem;

  logic [5:0] d, dn;
  logic       par, cur_rd, cur_bit, last_op;
  logic [ADDR_W-1:0] end_addr;

  assign d        = desc(algo_q, elem);
  assign dn       = desc(algo_q, elem + 2'd1);
  assign par      = addr[COL_W] ^ addr[0];
  assign cur_rd   = !opi && d[2];
  assign cur_bit  = (opi ? d[0] : d[1]) ^ ((algo_q == 2'd2) && par);
  assign last_op  = (opi == d[3]);
  assign end_addr = d[4] ? '0 : TOP;

  assign mem_we    = run && !cur_rd;
  assign mem_re    = run && cur_rd;
  assign mem_addr  = addr;
  assign mem_wdata = {DATA_W{cur_bit}};
  assign busy      = run || fin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; fin <= 1'b0; done <= 1'b0; opi <= 1'b0;
      algo_q <= '0; elem <= '0; addr <= '0;
    end else if (start && !busy) begin
      algo_q <= algo; elem <= '0; addr <= '0; opi <= 1'b0; done <= 1'b0;
      run <= (algo != 2'd3);
      fin <= (algo == 2'd3);
    end else if (run) begin
      opi <= !last_op;
      if (last_op) begin
        if (addr == end_addr) begin
          if (d[5]) begin
            run <= 1'b0;
            fin <= 1'b1;
          end else begin
            elem <= elem + 2'd1;
            addr <= dn[4] ? TOP : '0;
          end
        end else begin
          addr <= d[4] ? addr - 1'b1 : addr + 1'b1;
        end
      end
    end else if (fin) begin
      fin  <= 1'b0;
      done <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0; rd_exp <= 1'b0; rd_addr <= '0; rd_elem <= '0;
      fail <= 1'b0; fail_addr <= '0; fail_elem <= '0; fail_data <= '0;
    end else begin
      rd_pend <= mem_re;
      rd_exp  <= cur_bit;
      rd_addr <= addr;
      rd_elem <= elem;
      if (start && !busy) begin
        fail <= 1'b0; fail_addr <= '0; fail_elem <= '0; fail_data <= '0;
      end else if (rd_pend && !fail && (mem_rdata != {DATA_W{rd_exp}})) begin
        fail      <= 1'b1;
        fail_addr <= rd_addr;
        fail_elem <= rd_elem;
        fail_data <= mem_rdata;
      end
    end
  end
endmodule

// File: rtl/mbist_march_chk.sv
module mbist_march_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              mem_we,
  input logic              mem_re,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [ADDR_W-1:0] fail_addr,
  input logic [1:0]        fail_elem,
  input logic [DATA_W-1:0] fail_data
);
  p_single_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we && !mem_re);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !mem_we && !mem_re && !busy);

  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !start |=> fail && $stable(fail_addr) && $stable(fail_elem) && $stable(fail_data));

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  p_busy_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && done |-> 1'b0);
endmodule

bind mbist_march mbist_march_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_we(mem_we), .mem_re(mem_re),
  .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
  .fail_elem(fail_elem), .fail_data(fail_data)
);

// File: tb/mbist_march_tb_top.sv
module mbist_march_tb_top;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int ROW_W  = 2;
  localparam int N      = 1 << ADDR_W;
  localparam int COL_W  = ADDR_W - ROW_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] algo = 2'd0;
  logic mem_we, mem_re, busy, done, fail;
  logic [ADDR_W-1:0] mem_addr, fail_addr;
  logic [DATA_W-1:0] mem_wdata, fail_data;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic [1:0] fail_elem;

  always #4 clk = ~clk;

  mbist_march #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_W(ROW_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .algo(algo),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail),
    .fail_addr(fail_addr), .fail_elem(fail_elem), .fail_data(fail_data));

  logic [DATA_W-1:0] mem [N];
  int f_n = 0;
  int f_a [2];
  int f_b [2];
  logic f_s [2];

  function automatic logic [DATA_W-1:0] faulty(input logic [DATA_W-1:0] w, input int a);
    logic [DATA_W-1:0] r = w;
    for (int i = 0; i < f_n; i++)
      if (f_a[i] == a) r[f_b[i]] = f_s[i];
    return r;
  endfunction

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= faulty(mem[mem_addr], int'(mem_addr));
  end

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit parity(input int a);
    return 1'(a >> COL_W) ^ 1'(a);
  endfunction

  function automatic int total_ops(input int a);
    return (a == 0) ? 5 * N : (a == 3) ? 0 : 4 * N;
  endfunction

  // returns {we, value, addr}
  function automatic logic [ADDR_W+1:0] exp_op(input int a, input int k);
    int e, ad, j;
    bit we, v;
    if (a == 0) begin
      if (k < N) begin e = 0; ad = k; we = 1; v = 0; end
      else if (k < 3 * N) begin
        j = k - N; ad = j / 2; we = (j % 2) == 1; v = we;
      end else begin
        j = k - 3 * N; ad = N - 1 - j / 2; we = (j % 2) == 1; v = !we;
      end
    end else begin
      e = k / N; ad = k % N; we = (e % 2) == 0; v = (e >= 2);
      if (a == 2) v = v ^ parity(ad);
    end
    return {we, v, ADDR_W'(ad)};
  endfunction

  function automatic int exp_elem(input int a, input int ad, input bit s);
    if (a == 0) return s ? 1 : 2;
    if (a == 1) return s ? 1 : 3;
    return (s != parity(ad)) ? 1 : 3;
  endfunction

  function automatic bit pat_bit(input int a, input int e, input int ad);
    if (a == 2) return parity(ad) ^ (e == 3);
    if (a == 0) return e == 2;
    return e == 3;
  endfunction

  task automatic run_algo(input int a, input bit inject, input bit exp_fail,
                          input int ef_addr, input int ef_elem, input int ef_bit, input string tag);
    int k = 0;
    int errs = 0;
    int cyc = 0;
    logic [ADDR_W+1:0] eo;
    logic [DATA_W-1:0] ew;
    @(negedge clk);
    start = 1'b1; algo = 2'(a);
    @(negedge clk);
    start = 1'b0; algo = 2'd0;
    while (!done && cyc < 2000) begin
      if (mem_we && mem_re) errs++;
      if (mem_we || mem_re) begin
        eo = exp_op(a, k);
        if (mem_we != eo[ADDR_W+1] || mem_addr != eo[ADDR_W-1:0]) errs++;
        if (mem_we && mem_wdata != {DATA_W{eo[ADDR_W]}}) errs++;
        k++;
      end
      if (inject && k == 10) begin start = 1'b1; algo = 2'd1; end
      else begin start = 1'b0; algo = 2'd0; end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(done, tag, "done reached", int'(done), 1);
    check(errs == 0, tag, "access order mismatches", errs, 0);
    check(k == total_ops(a), tag, "access count", k, total_ops(a));
    check(fail == exp_fail, {tag, " R8"}, "fail flag", int'(fail), int'(exp_fail));
    if (exp_fail) begin
      ew = {DATA_W{pat_bit(a, ef_elem, ef_addr)}};
      ew[ef_bit] = ~ew[ef_bit];
      check(int'(fail_addr) == ef_addr, "R8", "fail_addr", int'(fail_addr), ef_addr);
      check(int'(fail_elem) == ef_elem, "R8", "fail_elem", int'(fail_elem), ef_elem);
      check(fail_data == ew, "R8", "fail_data", int'(fail_data), int'(ew));
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(done && fail == exp_fail && !mem_we && !mem_re, "R9", "hold after done",
            int'({done, fail, mem_we, mem_re}), int'({1'b1, exp_fail, 2'b00}));
    end
  endtask

  initial begin
    int seed, a, ad, b;
    bit s, hasf;
    seed = $urandom(20240611);
    for (int i = 0; i < N; i++) mem[i] = DATA_W'($urandom);
    repeat (3) @(negedge clk);
    check(!busy && !done && !fail && !mem_we && !mem_re, "R1", "reset state",
          int'({busy, done, fail, mem_we, mem_re}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    f_n = 0;
    run_algo(0, 0, 0, 0, 0, 0, "R4 R7");
    run_algo(1, 0, 0, 0, 0, 0, "R5");
    run_algo(2, 0, 0, 0, 0, 0, "R6");
    run_algo(3, 0, 0, 0, 0, 0, "R10");
    run_algo(0, 1, 0, 0, 0, 0, "R2");

    f_n = 2; f_a[0] = 3; f_a[1] = 12; f_b[0] = 0; f_b[1] = 5; f_s[0] = 1; f_s[1] = 1;
    run_algo(0, 0, 1, 3, 1, 0, "R7 ascending first fail");
    f_s[0] = 0; f_s[1] = 0;
    run_algo(0, 0, 1, 12, 2, 5, "R7 descending first fail");

    for (int t = 0; t < 24; t++) begin
      a = int'($urandom % 3);
      hasf = ($urandom % 4) != 0;
      ad = int'($urandom % N);
      b = int'($urandom % DATA_W);
      s = 1'($urandom);
      f_n = hasf ? 1 : 0; f_a[0] = ad; f_b[0] = b; f_s[0] = s;
      run_algo(a, 0, hasf, ad, hasf ? exp_elem(a, ad, s) : 0, b, "R8 random");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule